// File: doc/BRIEF.md
# Chainable Serial Trim Control Latch

This block is the digital control port of a two-path gain and phase trim device. A host shifts a control word in on a serial data line, one bit per rising edge of a serial clock. A separate load clock then copies the newest 16 bits into two output registers, one for each RF path. Each path register holds a 5-bit attenuation step code (0.25 dB per step) and a 3-bit phase step code (6.5 degrees of lag per step). These registers drive the analog trim circuits directly.

The shift chain is 32 stages deep, and its last stage is always driven onto a serial output pin. A second device wired to that pin therefore receives the same stream 32 serial clocks later. A disable input forces both paths to zero codes and freezes the serial port. A strap input chooses whether reset leaves the path registers at all zeros or at all ones. The serial and load clocks are slow, asynchronous inputs. They are sampled by a fast system clock through two-stage synchronizers, and their edges are detected in that clock domain.

Top module: `trim_serial_latch`

## Requirements
- R1: Each rising edge of `ser_clk` shifts the chain up by one stage, and the synchronized `ser_din` value enters stage 0.
- R2: `ser_dout` shows stage 31 of the chain. A bit sent on the line comes out 32 serial clocks later, and `ser_dout` changes only after a serial clock edge.
- R3: The first 8 bits sent after the final 16 bits are framed go to the carrier path (`c_*`). The 8 bits sent after them go to the peaking path (`p_*`). Each byte is sent most significant bit first.
- R4: Within a path byte, bits 7..3 form the attenuation code and bits 2..0 form the phase code.
- R5: The path outputs change only on a rising edge of `ld_clk`. Shifting alone leaves them unchanged.
- R6: While `port_dis` is 1, all four path outputs read 0 in the same cycle.
- R7: While `port_dis` is 1, `ser_clk` and `ld_clk` edges are ignored. Once `port_dis` returns to 0, the outputs show the values latched before the disable, and the chain contents are unchanged.
- R8: A reset with `pwr_max` = 0 loads zeros into both path registers and clears the chain.
- R9: A reset with `pwr_max` = 1 loads all ones into both path registers (attenuation 31, phase 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data in |
| ld_clk | input | 1 | Load clock; a rising edge latches the word |
| port_dis | input | 1 | 1 = force zero codes and freeze the port |
| pwr_max | input | 1 | Reset strap: 1 = all-ones default, 0 = zeros |
| ser_dout | output | 1 | Last chain stage, for daisy chaining |
| c_atten | output | 5 | Carrier attenuation code |
| c_phase | output | 3 | Carrier phase code |
| p_atten | output | 5 | Peaking attenuation code |
| p_phase | output | 3 | Peaking phase code |

## Verification
Several behaviours are checked by the assertions on every cycle. These are the one-stage shift on each detected serial edge, the stability of `ser_dout` between edges, and the hold of the path registers when no load fires or while disabled. They also cover the forced zero outputs under `port_dis` and the strap-selected reset value. Other behaviours can only be shown by the bench scenarios. These are the bit ordering of the word across the two paths, the field split within each byte, the full 32-clock daisy-chain delay of a known pattern, and the restored values after a disable window during which both serial and load strobes were sent.

// File: rtl/trim_pkg.sv
package trim_pkg;
   localparam int unsigned DEF_CHAIN_W = 32;
   localparam int unsigned DEF_ATT_W   = 5;
   localparam int unsigned DEF_PH_W    = 3;
   localparam int unsigned DEF_SYNC    = 2;
   localparam int unsigned NUM_PATHS   = 2;

   // path index; carrier occupies the upper byte of the latched word
   typedef enum logic [0:0] {
      PATH_CARRIER = 1'b0,
      PATH_PEAK    = 1'b1
   } path_e;
endpackage

// File: rtl/sync_cell.sv
module sync_cell #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad
      $error("sync_cell: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], async_i};
   end

   assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic lvl;
   logic lvl_q;

   sync_cell #(.STAGES(STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(async_i),
      .sync_o (lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise_o = lvl & ~lvl_q;
endmodule

// File: rtl/path_reg.sv
module path_reg #(
   parameter int unsigned PATH_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_max,
   input  logic              load,
   input  logic [PATH_W-1:0] d,
   output logic [PATH_W-1:0] q
);
   if (PATH_W < 1) begin : g_bad
      $error("path_reg: PATH_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= pwr_max ? '1 : '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/trim_serial_latch.sv
module trim_serial_latch
   import trim_pkg::*;
#(
   parameter int unsigned CHAIN_W = DEF_CHAIN_W,
   parameter int unsigned ATT_W   = DEF_ATT_W,
   parameter int unsigned PH_W    = DEF_PH_W,
   parameter int unsigned SYNC    = DEF_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_din,
   input  logic             ld_clk,
   input  logic             port_dis,
   input  logic             pwr_max,
   output logic             ser_dout,
   output logic [ATT_W-1:0] c_atten,
   output logic [PH_W-1:0]  c_phase,
   output logic [ATT_W-1:0] p_atten,
   output logic [PH_W-1:0]  p_phase
);
   localparam int unsigned PATH_W = ATT_W + PH_W;
   localparam int unsigned WORD_W = NUM_PATHS * PATH_W;

   if (CHAIN_W < WORD_W) begin : g_bad_chain
      $error("trim_serial_latch: CHAIN_W shorter than control word");
   end
   if (ATT_W < 1 || PH_W < 1) begin : g_bad_field
      $error("trim_serial_latch: field widths must be positive");
   end

   logic sh_rise, ld_rise, din_s, dis_s;
   logic sh_fire, ld_fire;
   logic [CHAIN_W-1:0] chain;
   logic [WORD_W-1:0]  held;

   edge_sync #(.STAGES(SYNC)) i_sh_edge (
      .clk(clk), .rst_n(rst_n), .async_i(ser_clk), .rise_o(sh_rise)
   );
   edge_sync #(.STAGES(SYNC)) i_ld_edge (
      .clk(clk), .rst_n(rst_n), .async_i(ld_clk), .rise_o(ld_rise)
   );
   sync_cell #(.STAGES(SYNC)) i_din_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ser_din), .sync_o(din_s)
   );
   sync_cell #(.STAGES(SYNC)) i_dis_sync (
      .clk(clk), .rst_n(rst_n), .async_i(port_dis), .sync_o(dis_s)
   );

   assign sh_fire = sh_rise & ~dis_s;
   assign ld_fire = ld_rise & ~dis_s;

   // serial chain: newest bit at stage 0, last stage feeds the next device
   always_ff @(posedge clk) begin
      if (!rst_n)       chain <= '0;
      else if (sh_fire) chain <= {chain[CHAIN_W-2:0], din_s};
   end
   assign ser_dout = chain[CHAIN_W-1];

   // one output register per path; path 0 takes the upper byte of the word
   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      localparam int unsigned HI = WORD_W - 1 - p * PATH_W;
      path_reg #(.PATH_W(PATH_W)) i_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .pwr_max(pwr_max),
         .load   (ld_fire),
         .d      (chain[HI -: PATH_W]),
         .q      (held[HI -: PATH_W])
      );
   end

   localparam int unsigned C_HI = WORD_W - 1 - int'(PATH_CARRIER) * PATH_W;
   localparam int unsigned P_HI = WORD_W - 1 - int'(PATH_PEAK) * PATH_W;

   always_comb begin
      if (port_dis) begin
         c_atten = '0;
         c_phase = '0;
         p_atten = '0;
         p_phase = '0;
      end else begin
         c_atten = held[C_HI -: ATT_W];
         c_phase = held[C_HI - ATT_W -: PH_W];
         p_atten = held[P_HI -: ATT_W];
         p_phase = held[P_HI - ATT_W -: PH_W];
      end
   end
endmodule

// File: rtl/trim_serial_latch_chk.sv
module trim_serial_latch_chk #(
   parameter int unsigned CHAIN_W = 32,
   parameter int unsigned ATT_W   = 5,
   parameter int unsigned PH_W    = 3,
   parameter int unsigned WORD_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               port_dis,
   input logic               pwr_max,
   input logic               dis_s,
   input logic               sh_fire,
   input logic               ld_fire,
   input logic               din_s,
   input logic               ser_dout,
   input logic [CHAIN_W-1:0] chain,
   input logic [WORD_W-1:0]  held,
   input logic [ATT_W-1:0]   c_atten,
   input logic [PH_W-1:0]    c_phase,
   input logic [ATT_W-1:0]   p_atten,
   input logic [PH_W-1:0]    p_phase
);
   a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      sh_fire |=> chain == {$past(chain[CHAIN_W-2:0]), $past(din_s)});

   a_r2_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_fire |=> $stable(ser_dout));

   a_r2_dout_advance: assert property (@(posedge clk) disable iff (!rst_n)
      sh_fire |=> ser_dout == $past(chain[CHAIN_W-2]));

   a_r5_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_fire |=> $stable(held));

   a_r6_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis |-> (c_atten == '0 && c_phase == '0 && p_atten == '0 && p_phase == '0));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      dis_s |=> ($stable(held) && $stable(chain)));

   // R8 and R9: the register value set while in reset follows the strap
   a_r9_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> held == ($past(pwr_max) ? {WORD_W{1'b1}} : {WORD_W{1'b0}}));
endmodule

bind trim_serial_latch trim_serial_latch_chk #(
   .CHAIN_W(CHAIN_W), .ATT_W(ATT_W), .PH_W(PH_W), .WORD_W(WORD_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .pwr_max(pwr_max),
   .dis_s(dis_s), .sh_fire(sh_fire), .ld_fire(ld_fire), .din_s(din_s),
   .ser_dout(ser_dout), .chain(chain), .held(held),
   .c_atten(c_atten), .c_phase(c_phase), .p_atten(p_atten), .p_phase(p_phase)
);

// File: tb/test_trim_serial_latch.sv
module test_trim_serial_latch;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_din = 1'b0, ld_clk = 1'b0;
   logic port_dis = 1'b0, pwr_max = 1'b0;
   logic ser_dout;
   logic [4:0] c_atten, p_atten;
   logic [2:0] c_phase, p_phase;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   trim_serial_latch i_trim_serial_latch (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ld_clk(ld_clk), .port_dis(port_dis), .pwr_max(pwr_max),
      .ser_dout(ser_dout), .c_atten(c_atten), .c_phase(c_phase),
      .p_atten(p_atten), .p_phase(p_phase)
   );

   localparam int NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{
      16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234, 16'h8001, 16'h7E18
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_din = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
   endtask

   task automatic shift_word16(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic pulse_ld();
      ld_clk = 1'b1;
      wait_clk(4);
      ld_clk = 1'b0;
      wait_clk(4);
   endtask

   task automatic do_reset(input logic strap);
      pwr_max = strap;
      rst_n = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
   endtask

   // expected fields computed from R3/R4: carrier = upper byte, atten = bits 7..3
   task automatic check_word(input string req, input logic [15:0] w);
      check({req, " c_atten"}, 32'(c_atten), 32'(w[15:11]));
      check({req, " c_phase"}, 32'(c_phase), 32'(w[10:8]));
      check({req, " p_atten"}, 32'(p_atten), 32'(w[7:3]));
      check({req, " p_phase"}, 32'(p_phase), 32'(w[2:0]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] pat;
      logic [31:0] seen;
      // R8 reset state
      do_reset(1'b0);
      check_word("R8 reset zeros", 16'h0000);
      check("R8 chain cleared", 32'(ser_dout), 32'd0);

      // table walk: R3 R4 R5
      for (int v = 0; v < NVEC; v++) begin
         shift_word16(VEC[v]);
         if (v > 0) check_word("R5 held before load", VEC[v-1]);
         pulse_ld();
         check_word("R3 R4 latched word", VEC[v]);
      end

      // R2 daisy chain: 32-bit pattern emerges msb first
      pat = 32'hC0FFEE15;
      for (int i = 31; i >= 0; i--) shift_bit(pat[i]);
      check("R2 first bit at dout", 32'(ser_dout), 32'(pat[31]));
      seen = '0;
      for (int i = 0; i < 32; i++) begin
         seen = {seen[30:0], ser_dout};
         shift_bit(1'b0);
      end
      check("R1 R2 delayed stream", seen, pat);
      check("R1 chain flushed", 32'(ser_dout), 32'd0);

      // R6 R7 disable override
      shift_word16(16'h5A96);
      pulse_ld();
      check_word("R3 pre-disable", 16'h5A96);
      port_dis = 1'b1;
      #1;
      check_word("R6 forced zero", 16'h0000);
      wait_clk(4);
      shift_word16(16'hFFFF);
      pulse_ld();
      check_word("R6 still forced", 16'h0000);
      port_dis = 1'b0;
      wait_clk(4);
      check_word("R7 restored latch", 16'h5A96);
      pulse_ld();
      check_word("R7 chain untouched", 16'h5A96);

      // R9 reset with strap high
      do_reset(1'b1);
      check_word("R9 reset ones", 16'hFFFF);
      do_reset(1'b0);
      check_word("R8 reset zeros again", 16'h0000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule